// File: doc/BRIEF.md
# Lockable Translation Cache with Victim Pointer

This block is a small, fully associative address translation cache for a device-side MMU. Each entry maps one device virtual page to a physical frame, with a per-entry page size of 4 KB, 64 KB, 1 MB or 16 MB and a byte of attributes. Software fills and maintains the cache through a narrow register port. It stages a tag word and a data word, then issues commands that write an entry, invalidate the entries covering one address, or invalidate everything. Any entry can be read back by pointing the replacement pointer at it.

Replacement is fully under software view. A victim pointer selects the next slot for an ordinary fill. It advances after each fill, and past the last slot it returns to a movable lockdown base rather than to slot zero. Fills flagged as preserved go to the base slot and push the base upward, so slots below the base are never chosen as victims. A lookup port translates one address per cycle combinationally. The lowest-numbered covering entry wins. A lookup that finds nothing produces a one-cycle miss pulse and captures the address in a fault register.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, the lock register reads 0, the fault register reads 0 and no lookup hits.
- R2: Writing 1 to command bit 0 (register 3) stores the staged tag word (register 1) with its valid bit (bit 2) forced to 1, and the staged data word (register 2), into the selected slot. Register 4 then returns the slot's tag word: page number [31:12], preserved flag [3], valid [2], size [1:0], and zeros elsewhere. Register 5 returns page frame [31:12] and attributes [7:0], with zeros elsewhere. Both read the slot chosen by the victim field.
- R3: An ordinary fill (tag bit 3 clear) writes the victim slot and then advances the victim field by one. When the field would reach the entry count, it becomes the lockdown base instead.
- R4: A preserved fill (tag bit 3 set) writes the slot at the lockdown base. The base then advances by one, and the victim field takes the new base value.
- R5: When the base equals the entry count, register 0 bit 15 reads 1 and fills of either kind change neither entries nor the lock register.
- R6: Size code 0/1/2/3 selects 4 KB/64 KB/1 MB/16 MB. A lookup hits when the masked page numbers agree. The physical address takes the frame bits above the page offset and the lookup address bits within it, and the attributes of the matching entry are returned.
- R7: When several valid entries cover a lookup address, the lowest-numbered one supplies the translation.
- R8: A lookup with no covering entry raises the miss output for exactly the following cycle and loads the address into register 6. Hits and idle cycles leave register 6 unchanged and the miss output low.
- R9: Command bit 1 invalidates every valid entry whose page, at that entry's own size, covers the address in the staged tag word. Other entries are untouched.
- R10: Command bit 2 invalidates all entries and leaves the base and victim fields unchanged.
- R11: A write to register 0 sets the base from bits [14:10] and the victim from bits [8:4], each taken modulo the entry count. Register 0 reads base at [14:10] and victim at [8:4].
- R12: When several command bits are set together, bit 2 takes effect alone, and otherwise bit 1 takes effect without bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 lock, 1 staged tag, 2 staged data, 3 command, 4 tag read-back, 5 data read-back, 6 fault address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup device virtual address |
| lk_hit | output | 1 | Lookup found a covering entry |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | 8 | Attributes of the matching entry |
| lk_miss | output | 1 | One-cycle pulse after a missed lookup |

## Verification
The bench builds the block with 8 entries rather than the default 32. This lets the lockdown base reach the entry count within a few fills, so the full state, its status bit and the rejection of further fills can all be observed. The smaller count also makes modulo-8 truncation of lock writes and victim wrap to a non-zero base show up within short directed sequences. Random fills over two 16 MB regions create frequent overlapping pages of mixed sizes, which exercises lowest-slot priority and size-dependent flushes against a bench model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int PN_W   = VA_W - OFF_W;
    localparam int ATTR_W = 8;
    localparam int LFLD_W = 5;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pgsz_e;

    typedef enum logic [2:0] {
        RA_LOCK  = 3'd0,
        RA_TAG   = 3'd1,
        RA_DATA  = 3'd2,
        RA_CMD   = 3'd3,
        RA_RDTAG = 3'd4,
        RA_RDDAT = 3'd5,
        RA_FAULT = 3'd6,
        RA_NONE  = 3'd7
    } reg_e;

    typedef struct packed {
        logic              valid;
        logic              pres;
        pgsz_e             sz;
        logic [PN_W-1:0]   vpn;
        logic [PN_W-1:0]   ppn;
        logic [ATTR_W-1:0] attr;
    } entry_t;

    function automatic logic [PN_W-1:0] page_mask(input pgsz_e sz);
        case (sz)
            PG_4K:   page_mask = {PN_W{1'b1}};
            PG_64K:  page_mask = {{(PN_W-4){1'b1}}, 4'h0};
            PG_1M:   page_mask = {{(PN_W-8){1'b1}}, 8'h00};
            default: page_mask = {{(PN_W-12){1'b1}}, 12'h000};
        endcase
    endfunction

    function automatic logic covers(input entry_t e, input logic [VA_W-1:0] va);
        covers = e.valid &&
                 (((e.vpn ^ va[VA_W-1:OFF_W]) & page_mask(e.sz)) == '0);
    endfunction

    function automatic logic [VA_W-1:0] xlate(input entry_t e, input logic [VA_W-1:0] va);
        logic [PN_W-1:0] m;
        m = page_mask(e.sz);
        xlate = {(e.ppn & m) | (va[VA_W-1:OFF_W] & ~m), va[OFF_W-1:0]};
    endfunction

    function automatic entry_t make_entry(input logic [31:0] tag, input logic [31:0] dat);
        entry_t e;
        e.valid = 1'b1;
        e.pres  = tag[3];
        e.sz    = pgsz_e'(tag[1:0]);
        e.vpn   = tag[31:OFF_W];
        e.ppn   = dat[31:OFF_W];
        e.attr  = dat[ATTR_W-1:0];
        make_entry = e;
    endfunction

    function automatic logic [31:0] tag_word(input entry_t e);
        tag_word = {e.vpn, 8'h00, e.pres, e.valid, e.sz};
    endfunction

    function automatic logic [31:0] data_word(input entry_t e);
        data_word = {e.ppn, {(OFF_W-ATTR_W){1'b0}}, e.attr};
    endfunction

endpackage

// File: rtl/xlat_repl.sv
module xlat_repl
    import xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 lock_we,
    input  logic [LFLD_W-1:0]                    base_in,
    input  logic [LFLD_W-1:0]                    vict_in,
    input  logic                                 fill_req,
    input  logic                                 fill_pres,
    output logic [$clog2(NUM_ENTRIES):0]         base,
    output logic [$clog2(NUM_ENTRIES):0]         victim,
    output logic                                 full,
    output logic                                 wr_en,
    output logic [$clog2(NUM_ENTRIES)-1:0]       wr_idx
);
    localparam int IDX_W = $clog2(NUM_ENTRIES);
    localparam int CNT_W = IDX_W + 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(NUM_ENTRIES);

    logic [CNT_W-1:0] base_inc;
    logic [CNT_W-1:0] vict_inc;

    assign full     = (base == LIMIT);
    assign wr_en    = fill_req && !full;
    assign wr_idx   = fill_pres ? base[IDX_W-1:0] : victim[IDX_W-1:0];
    assign base_inc = base + CNT_W'(1);
    assign vict_inc = victim + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            base   <= '0;
            victim <= '0;
        end else if (lock_we) begin
            base   <= CNT_W'(base_in[IDX_W-1:0]);
            victim <= CNT_W'(vict_in[IDX_W-1:0]);
        end else if (wr_en) begin
            if (fill_pres) begin
                base   <= base_inc;
                victim <= base_inc;
            end else if (vict_inc == LIMIT) begin
                victim <= base;
            end else begin
                victim <= vict_inc;
            end
        end
    end

    // R4: a granted preserved fill moves the base up by one
    p_base_step_r4: assert property (@(posedge clk) disable iff (rst)
        (fill_req && fill_pres && !full && !lock_we) |=> (base == $past(base) + CNT_W'(1)));

    // R3: an ordinary fill from the last slot returns the victim to the base
    p_wrap_to_base_r3: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !fill_pres && !full && !lock_we && victim == LIMIT - CNT_W'(1))
        |=> (victim == $past(base)));

    // R5: fills in the full state leave the lock fields alone
    p_full_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (fill_req && full && !lock_we) |=> ($stable(base) && $stable(victim)));

    // R3: pointers never pass the entry count
    p_ptr_range_r3: assert property (@(posedge clk) disable iff (rst)
        (base <= LIMIT) && (victim <= LIMIT));

endmodule

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [$clog2(NUM_ENTRIES)-1:0]     wr_idx,
    input  entry_t                             wr_entry,
    input  logic                               flush_one,
    input  logic [VA_W-1:0]                    flush_va,
    input  logic                               flush_all,
    output entry_t [NUM_ENTRIES-1:0]           ents
);
    logic [NUM_ENTRIES-1:0] vbits;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[i] <= '0;
            end else if (flush_all) begin
                ents[i].valid <= 1'b0;
            end else if (flush_one) begin
                if (covers(ents[i], flush_va)) begin
                    ents[i].valid <= 1'b0;
                end
            end else if (wr_en && (wr_idx == i)) begin
                ents[i] <= wr_entry;
            end
        end
        assign vbits[i] = ents[i].valid;
    end

    // R10: a global invalidate leaves no valid slot
    p_gflush_clear_r10: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (vbits == '0));

    // R2: a written slot is valid on the next cycle
    p_fill_valid_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush_all && !flush_one) |=> vbits[$past(wr_idx)]);

endmodule

// File: rtl/xlat_lookup.sv
module xlat_lookup
    import xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input  entry_t [NUM_ENTRIES-1:0]   ents,
    input  logic                       lk_valid,
    input  logic [VA_W-1:0]            lk_va,
    output logic                       hit,
    output logic [VA_W-1:0]            pa,
    output logic [ATTR_W-1:0]          attr
);
    localparam int IDX_W = $clog2(NUM_ENTRIES);

    logic [NUM_ENTRIES-1:0] cover_vec;
    logic [IDX_W-1:0]       sel;
    logic                   any;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        assign cover_vec[i] = covers(ents[i], lk_va);
    end

    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (cover_vec[i]) begin
                sel = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

    assign hit  = lk_valid && any;
    assign pa   = xlate(ents[sel], lk_va);
    assign attr = ents[sel].attr;

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        lk_valid,
    input  logic [31:0] lk_va,
    output logic        lk_hit,
    output logic [31:0] lk_pa,
    output logic [7:0]  lk_attr,
    output logic        lk_miss
);
    localparam int IDX_W = $clog2(NUM_ENTRIES);
    localparam int CNT_W = IDX_W + 1;

    logic [31:0]      tag_stage;
    logic [31:0]      dat_stage;
    logic [31:0]      fault_va;
    logic             lock_we, cmd_we;
    logic             do_gflush, do_flush1, do_fill;
    logic [CNT_W-1:0] base, victim;
    logic             full, wr_en;
    logic [IDX_W-1:0] wr_idx;
    entry_t [NUM_ENTRIES-1:0] ents;
    entry_t           rd_ent;
    reg_e             ra;

    assign ra        = reg_e'(reg_addr);
    assign lock_we   = reg_we && (ra == RA_LOCK);
    assign cmd_we    = reg_we && (ra == RA_CMD);
    assign do_gflush = cmd_we && reg_wdata[2];
    assign do_flush1 = cmd_we && reg_wdata[1] && !reg_wdata[2];
    assign do_fill   = cmd_we && reg_wdata[0] && !reg_wdata[1] && !reg_wdata[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_stage <= '0;
            dat_stage <= '0;
        end else if (reg_we && ra == RA_TAG) begin
            tag_stage <= reg_wdata;
        end else if (reg_we && ra == RA_DATA) begin
            dat_stage <= reg_wdata;
        end
    end

    xlat_repl #(.NUM_ENTRIES(NUM_ENTRIES)) u_repl (
        .clk       (clk),
        .rst       (rst),
        .lock_we   (lock_we),
        .base_in   (reg_wdata[14:10]),
        .vict_in   (reg_wdata[8:4]),
        .fill_req  (do_fill),
        .fill_pres (tag_stage[3]),
        .base      (base),
        .victim    (victim),
        .full      (full),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx)
    );

    xlat_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_entry  (make_entry(tag_stage, dat_stage)),
        .flush_one (do_flush1),
        .flush_va  (tag_stage),
        .flush_all (do_gflush),
        .ents      (ents)
    );

    xlat_lookup #(.NUM_ENTRIES(NUM_ENTRIES)) u_lookup (
        .ents     (ents),
        .lk_valid (lk_valid),
        .lk_va    (lk_va),
        .hit      (lk_hit),
        .pa       (lk_pa),
        .attr     (lk_attr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_miss  <= 1'b0;
            fault_va <= '0;
        end else begin
            lk_miss <= lk_valid && !lk_hit;
            if (lk_valid && !lk_hit) begin
                fault_va <= lk_va;
            end
        end
    end

    assign rd_ent = ents[victim[IDX_W-1:0]];

    always_comb begin
        case (ra)
            RA_LOCK:  reg_rdata = {16'h0, full, LFLD_W'(base), 1'b0, LFLD_W'(victim), 4'h0};
            RA_TAG:   reg_rdata = tag_stage;
            RA_DATA:  reg_rdata = dat_stage;
            RA_RDTAG: reg_rdata = tag_word(rd_ent);
            RA_RDDAT: reg_rdata = data_word(rd_ent);
            RA_FAULT: reg_rdata = fault_va;
            default:  reg_rdata = '0;
        endcase
    end

    // R8: a missed lookup is followed by a one-cycle miss pulse
    p_miss_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_hit) |=> (lk_miss && fault_va == $past(lk_va)));

    // R8: no miss and no fault capture without a missed lookup
    p_fault_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(lk_valid && !lk_hit) |=> (!lk_miss && $stable(fault_va)));

endmodule

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic [7:0]  lk_attr;
    logic        lk_miss;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_tag [N];
    logic [31:0] m_dat [N];
    int          m_base, m_vict;
    logic [31:0] m_stag, m_sdat, m_fault;

    always #2 clk = ~clk;

    xlat_cache #(.NUM_ENTRIES(N)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr),
        .lk_miss(lk_miss)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] pmask(input logic [1:0] s);
        case (s)
            2'd0: pmask = 20'hFFFFF;
            2'd1: pmask = 20'hFFFF0;
            2'd2: pmask = 20'hFFF00;
            default: pmask = 20'hFF000;
        endcase
    endfunction

    function automatic bit m_cov(input int i, input logic [31:0] va);
        m_cov = m_tag[i][2] &&
                (((m_tag[i][31:12] ^ va[31:12]) & pmask(m_tag[i][1:0])) == 20'h0);
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_lock(input int b, input int v);
        wr(3'd0, (32'(b) << 10) | (32'(v) << 4));
        m_base = b % N;
        m_vict = v % N;
    endtask

    task automatic stage(input logic [31:0] t, input logic [31:0] d);
        wr(3'd1, t); wr(3'd2, d);
        m_stag = t; m_sdat = d;
    endtask

    task automatic cmd(input logic [2:0] c);
        wr(3'd3, {29'h0, c});
        if (c[2]) begin
            for (int i = 0; i < N; i++) m_tag[i][2] = 1'b0;
        end else if (c[1]) begin
            for (int i = 0; i < N; i++) if (m_cov(i, m_stag)) m_tag[i][2] = 1'b0;
        end else if (c[0] && m_base != N) begin
            int idx;
            idx = m_stag[3] ? m_base : m_vict;
            m_tag[idx] = {m_stag[31:12], 8'h00, m_stag[3], 1'b1, m_stag[1:0]};
            m_dat[idx] = {m_sdat[31:12], 4'h0, m_sdat[7:0]};
            if (m_stag[3]) begin
                m_base++;
                m_vict = m_base;
            end else begin
                m_vict++;
                if (m_vict == N) m_vict = m_base;
            end
        end
    endtask

    task automatic fill(input logic [31:0] t, input logic [31:0] d);
        stage(t, d);
        cmd(3'b001);
    endtask

    task automatic check_lock(input string req);
        logic [31:0] got, exp;
        exp = ((m_base == N) ? 32'h8000 : 32'h0) |
              (32'(m_base & 31) << 10) | (32'(m_vict & 31) << 4);
        rd(3'd0, got);
        chk(req, "lock register", got, exp);
    endtask

    task automatic check_entry(input string req, input int idx);
        logic [31:0] got;
        set_lock(m_base, idx);
        rd(3'd4, got);
        chk(req, "tag read-back", got, m_tag[idx]);
        rd(3'd5, got);
        chk(req, "data read-back", got, m_dat[idx]);
    endtask

    task automatic check_lookup(input string req, input logic [31:0] va);
        bit hit;
        logic [31:0] pa, got;
        logic [7:0] at;
        logic [19:0] m;
        hit = 0; pa = '0; at = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_cov(i, va)) begin
                hit = 1;
                m = pmask(m_tag[i][1:0]);
                pa = {(m_dat[i][31:12] & m) | (va[31:12] & ~m), va[11:0]};
                at = m_dat[i][7:0];
            end
        end
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va;
        #1;
        chk(req, "hit", 32'(lk_hit), 32'(hit));
        if (hit) begin
            chk(req, "physical address", lk_pa, pa);
            chk(req, "attributes", 32'(lk_attr), 32'(at));
        end
        @(negedge clk);
        lk_valid = 1'b0;
        if (!hit) m_fault = va;
        chk("R8", "miss pulse", 32'(lk_miss), 32'(!hit));
        rd(3'd6, got);
        chk("R8", "fault address", got, m_fault);
        @(negedge clk);
        chk("R8", "miss pulse width", 32'(lk_miss), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned seed_dummy;
        for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_dat[i] = '0; end
        m_base = 0; m_vict = 0; m_stag = '0; m_sdat = '0; m_fault = '0;
        seed_dummy = $urandom(32'h5eed_0017);

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(3'd0, v); chk("R1", "lock after reset", v, 32'h0);
        rd(3'd6, v); chk("R1", "fault after reset", v, 32'h0);
        rd(3'd4, v); chk("R1", "tag slot 0 after reset", v, 32'h0);
        check_lookup("R1", 32'h4012_3456);

        // R2/R3/R6: fills of each size
        fill({20'h40000, 12'h003}, {20'h7F000, 12'h05A});
        check_lock("R3");
        check_lookup("R6", 32'h4012_3456);
        fill({20'h40123, 12'h000}, {20'h00ABC, 12'h011});
        fill({20'h20010, 12'h001}, {20'h30000, 12'h022});
        fill({20'h10000, 12'h002}, {20'h55500, 12'h033});
        check_lock("R3");
        check_lookup("R6", 32'h2001_ABCD);
        check_lookup("R6", 32'h100A_BCDE);
        // R7: slot 0 (16 MB) and slot 1 (4 KB) both cover this address
        check_lookup("R7", 32'h4012_3456);
        check_entry("R2", 1);
        check_entry("R2", 3);
        set_lock(0, 4);

        // R9: flush by address
        stage({20'h40000, 12'h000}, 32'h0);
        cmd(3'b010);
        check_lookup("R9", 32'h4012_3456);
        check_lookup("R9", 32'h2001_ABCD);
        check_entry("R9", 0);
        set_lock(0, 4);

        // R8: miss then hit
        check_lookup("R8", 32'h9000_0000);
        check_lookup("R8", 32'h100A_BCDE);

        // R4: preserved fill
        fill({20'h60000, 12'h009}, {20'h61000, 12'h044});
        check_lock("R4");
        check_entry("R4", 0);
        check_lookup("R4", 32'h6000_F123);

        // R3: wrap to a non-zero base
        set_lock(2, 7);
        fill({20'h70000, 12'h000}, {20'h71000, 12'h055});
        check_lock("R3");
        check_lookup("R3", 32'h7000_0010);

        // R11: lock fields taken modulo the entry count
        set_lock(13, 20);
        check_lock("R11");

        // R5: base reaches the entry count
        set_lock(7, 3);
        fill({20'h50000, 12'h008}, {20'h51000, 12'h066});
        check_lock("R5");
        fill({20'h0A000, 12'h000}, {20'h0B000, 12'h077});
        check_lock("R5");
        check_lookup("R5", 32'h0A00_0000);
        fill({20'h0C000, 12'h008}, {20'h0D000, 12'h077});
        check_lock("R5");
        check_lookup("R5", 32'h0C00_0000);

        // R12: flush-by-address wins over fill
        set_lock(0, 0);
        stage({20'h20010, 12'h000}, {20'h12345, 12'h000});
        cmd(3'b011);
        check_lookup("R12", 32'h2001_ABCD);
        check_lock("R12");

        // R10/R12: global invalidate wins, lock unchanged
        set_lock(1, 3);
        cmd(3'b111);
        check_lock("R10");
        check_lookup("R10", 32'h100A_BCDE);
        check_lookup("R10", 32'h6000_F123);

        // Random phase
        set_lock(0, 0);
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [31:0] t;
            op = int'($urandom % 8);
            t = {8'h10 + 8'($urandom % 2), 12'($urandom), 8'h00, 1'b0, 1'b0, 2'($urandom)};
            if (op <= 2) begin
                fill(t, $urandom & 32'hFFFF_F0FF);
            end else if (op == 3) begin
                if (m_base < 3) t[3] = 1'b1;
                fill(t, $urandom & 32'hFFFF_F0FF);
            end else if (op == 4 && ($urandom % 4) == 0) begin
                stage(t, m_sdat);
                cmd(3'b010);
            end else begin
                check_lookup("R6", {8'h10 + 8'($urandom % 2), 24'($urandom)});
            end
            if ((it % 32) == 31) check_lock("R3");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule